// File: doc/BRIEF.md
# Buffered PWM Timer Channel

This block produces one pulse-width-modulated output from a free-running up-counter. The counter is driven by a power-of-two prescaler and wraps at a programmable modulo value. Software sets the period through the modulo register and the pulse width through a compare value. Two compare registers, A and B, can be linked so that they take turns owning the output. A new width written to the register that is not in use takes effect only at the next counter wrap, so a width change never produces a shortened or stretched pulse.

The output sits at its pulse level from each wrap until the compare point. It then returns to its idle level until the next wrap. Toggle-on-wrap, a forced full-duty mode and a level select cover the 0% and 100% cases and both output polarities. A single-cycle write port holds all configuration. Nothing is read back through it.

Register map, written with `wr_en`, `wr_addr` and `wr_data`:
- addr 0 is control: bit 0 halt, bit 1 clear (a pulse, not stored), bits 4:2 prescale select.
- addr 1 is modulo.
- addr 2 is compare A.
- addr 3 is compare B.
- addr 4 is channel config: bits 1:0 mode, bits 3:2 level select, bit 4 toggle-on-wrap, bit 5 full duty.

Top module: `pwm_pair_timer`

## Requirements
- R1: After reset the counter is halted (control bit 0 = 1). While halted, the counter and the output hold their values.
- R2: Writing control with bit 1 set zeroes the counter and the prescaler. The output level is left unchanged.
- R3: The counter advances on each prescaler tick and wraps to 0 after reaching the modulo value M. The period is therefore (M+1) ticks.
- R4: Prescale select S gives one tick every 2^S clock cycles, so the period and the pulse time scale by 2^S.
- R5: With toggle-on-wrap set and compare value C ≤ M, the output is at its pulse level for C ticks of each period. The compare returns it to idle. C = 0 gives no pulse.
- R6: Level select 2 gives a high pulse with a low idle level. Level select 3 gives a low pulse with a high idle level. Level select 0 or 1, or mode 0, disables the output, which is then driven low.
- R7: Mode 1 is unbuffered. Compare A alone is used, and a write to it changes the width within the current period.
- R8: Mode bit 1 set selects buffered operation and overrides mode bit 0. Compare A owns the output first. A write to the idle register passes ownership to it at the next wrap. Without such a write, ownership never changes.
- R9: In buffered mode, a write to the register that currently owns the output takes effect within the current period.
- R10: With toggle-on-wrap clear, compares can only drive the output to idle, so the duty is 0%.
- R11: With full duty and toggle-on-wrap both set, the output holds its pulse level at 100% duty.
- R12: With toggle-on-wrap set and C > M, the output inverts at each wrap. It is then at the pulse level for M+1 ticks out of every 2(M+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Write data |
| pwm_o | output | 1 | PWM output |

## Verification
The assertions check these rules on every cycle:
- Halt freezes the counter.
- Clear and wrap return the counter to zero.
- The phase bit moves only on a prescaler tick.
- A compare drives the phase to idle.
- Buffered ownership changes only at a wrap.
- Full duty forces the pulse level at a wrap.

Only the bench scenarios can show the measured quantities:
- Pulse width and period for each prescale and polarity.
- The immediate versus deferred effect of compare writes within a period.
- The 0%, 100% and toggle-only waveforms.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  localparam int ADDR_W = 3;
  localparam int PSEL_W = 3;
  localparam int PRE_W  = (1 << PSEL_W) - 1;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_MOD  = 3'd1,
    A_CMPA = 3'd2,
    A_CMPB = 3'd3,
    A_CFG  = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic       max_duty;
    logic       tov;
    logic [1:0] level;
    logic [1:0] mode;
  } chan_cfg_t;

  // A tick is due when the low S bits of the prescaler are all ones.
  function automatic logic tick_due(input logic [PRE_W-1:0] pre,
                                    input logic [PSEL_W-1:0] sel);
    logic [PRE_W-1:0] mask;
    mask = (PRE_W'(1) << sel) - PRE_W'(1);
    return (pre & mask) == mask;
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pair_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic [PSEL_W-1:0] sel,
  output logic              tick
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_q <= '0;
    else if (clr) pre_q <= '0;
    else if (run) pre_q <= pre_q + PRE_W'(1);
  end

  assign tick = run && !clr && tick_due(pre_q, sel);
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] modulo,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] nxt,
  output logic             wrap
);
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] m);
    return (c == m) ? '0 : c + CNT_W'(1);
  endfunction

  assign nxt  = next_count(cnt_q, modulo);
  assign wrap = tick && (cnt_q == modulo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (tick) cnt_q <= nxt;
  end
endmodule

// File: rtl/pwm_cmp_owner.sv
module pwm_cmp_owner #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             buffered,
  input  logic             wr_a,
  input  logic             wr_b,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             wrap,
  output logic [CNT_W-1:0] cmp_active,
  output logic             sel_b_q
);
  logic [CNT_W-1:0] a_q, b_q;
  logic             pend_q;
  logic             wr_idle;

  assign wr_idle    = sel_b_q ? wr_a : wr_b;
  assign cmp_active = (buffered && sel_b_q) ? b_q : a_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0; b_q <= '0; sel_b_q <= 1'b0; pend_q <= 1'b0;
    end else begin
      if (wr_a) a_q <= wr_val;
      if (wr_b) b_q <= wr_val;
      if (!buffered) begin
        sel_b_q <= 1'b0;
        pend_q  <= 1'b0;
      end else if (wrap && pend_q) begin
        sel_b_q <= ~sel_b_q;
        pend_q  <= sel_b_q ? wr_b : wr_a;
      end else if (wr_idle) begin
        pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pulse_high,
  input  logic tov,
  input  logic max_duty,
  input  logic wrap,
  input  logic cmp_hit,
  output logic act_q,
  output logic pwm_o
);
  logic force_full;
  assign force_full = tov && max_duty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     act_q <= 1'b0;
    else if (!en)                   act_q <= 1'b0;
    else if (wrap && force_full)    act_q <= 1'b1;
    else if (cmp_hit && !force_full) act_q <= 1'b0;
    else if (wrap && tov)           act_q <= ~act_q;
  end

  assign pwm_o = en && (pulse_high ? act_q : ~act_q);
endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              pwm_o
);
  localparam int CFG_W = $bits(chan_cfg_t);

  logic              halt_q;
  logic [PSEL_W-1:0] psel_q;
  logic [CNT_W-1:0]  mod_q;
  chan_cfg_t         cfg_q;

  logic ctrl_wr_w, cfg_wr_w, clr_w, wr_a_w, wr_b_w;
  logic tick_w, wrap_w, cmp_hit_w, en_w, buf_w, sel_b_q, act_q;
  logic [CNT_W-1:0] cnt_q, nxt_w, cmp_act_w;

  assign ctrl_wr_w = wr_en && (wr_addr == A_CTRL);
  assign cfg_wr_w  = wr_en && (wr_addr == A_CFG);
  assign wr_a_w    = wr_en && (wr_addr == A_CMPA);
  assign wr_b_w    = wr_en && (wr_addr == A_CMPB);
  assign clr_w     = ctrl_wr_w && wr_data[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b1;
      psel_q <= '0;
      mod_q  <= '1;
      cfg_q  <= '0;
    end else begin
      if (ctrl_wr_w) begin
        halt_q <= wr_data[0];
        psel_q <= wr_data[2 +: PSEL_W];
      end
      if (wr_en && (wr_addr == A_MOD)) mod_q <= wr_data;
      if (cfg_wr_w) cfg_q <= chan_cfg_t'(wr_data[CFG_W-1:0]);
    end
  end

  assign buf_w = cfg_q.mode[1];
  assign en_w  = cfg_q.level[1] && (cfg_q.mode != 2'b00);

  pwm_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .run(!halt_q), .clr(clr_w),
    .sel(psel_q), .tick(tick_w)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr_w), .tick(tick_w), .modulo(mod_q),
    .cnt_q(cnt_q), .nxt(nxt_w), .wrap(wrap_w)
  );

  pwm_cmp_owner #(.CNT_W(CNT_W)) u_own (
    .clk(clk), .rst_n(rst_n), .buffered(buf_w), .wr_a(wr_a_w), .wr_b(wr_b_w),
    .wr_val(wr_data), .wrap(wrap_w), .cmp_active(cmp_act_w), .sel_b_q(sel_b_q)
  );

  assign cmp_hit_w = tick_w && (nxt_w == cmp_act_w);

  pwm_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .en(en_w), .pulse_high(!cfg_q.level[0]),
    .tov(cfg_q.tov), .max_duty(cfg_q.max_duty), .wrap(wrap_w),
    .cmp_hit(cmp_hit_w), .act_q(act_q), .pwm_o(pwm_o)
  );
endmodule

// File: rtl/pwm_pair_timer_chk.sv
module pwm_pair_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             halt_q,
  input logic             clr_w,
  input logic             tick_w,
  input logic             wrap_w,
  input logic             cmp_hit_w,
  input logic             cfg_wr_w,
  input logic             en_w,
  input logic             buf_w,
  input logic             tov,
  input logic             max_duty,
  input logic             sel_b_q,
  input logic             act_q,
  input logic [CNT_W-1:0] cnt_q
);
  assert_halt_freeze_R1: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q && !clr_w |=> $stable(cnt_q));

  assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> cnt_q == '0);

  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_w |=> cnt_q == '0);

  assert_compare_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit_w && en_w && !(tov && max_duty) && !cfg_wr_w |=> !act_q);

  assert_disabled_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_w |=> !act_q);

  assert_owner_at_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_w && !wrap_w && !cfg_wr_w |=> $stable(sel_b_q));

  assert_full_duty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    en_w && wrap_w && tov && max_duty && !cfg_wr_w |=> act_q);

  assert_phase_on_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_w && !cfg_wr_w |=> $stable(act_q));
endmodule

bind pwm_pair_timer pwm_pair_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .halt_q(halt_q), .clr_w(clr_w), .tick_w(tick_w),
  .wrap_w(wrap_w), .cmp_hit_w(cmp_hit_w), .cfg_wr_w(cfg_wr_w), .en_w(en_w),
  .buf_w(buf_w), .tov(cfg_q.tov), .max_duty(cfg_q.max_duty),
  .sel_b_q(sel_b_q), .act_q(act_q), .cnt_q(cnt_q)
);

// File: tb/pwm_pair_timer_tb.sv
module pwm_pair_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_o;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pwm_pair_timer #(.CNT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_o(pwm_o)
  );

  // {modulo, compare, prescale select, level select}
  localparam logic [47:0] VEC [6] = '{
    {16'd9,  16'd3,  8'd0, 8'd2},
    {16'd19, 16'd10, 8'd0, 8'd2},
    {16'd9,  16'd4,  8'd1, 8'd2},
    {16'd14, 16'd5,  8'd2, 8'd3},
    {16'd24, 16'd24, 8'd0, 8'd2},
    {16'd9,  16'd1,  8'd0, 8'd3}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic setup(input int m, input int c, input int ps, input int cfg);
    wr(3'd0, 16'(3 + (ps << 2)));
    wr(3'd1, 16'(m));
    wr(3'd2, 16'(c));
    wr(3'd4, 16'(cfg));
    wr(3'd0, 16'(ps << 2));
  endtask

  function automatic logic smp(input bit hi);
    return hi ? pwm_o : ~pwm_o;
  endfunction

  task automatic wait_rise(input bit hi);
    logic prev;
    prev = smp(hi);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!prev && smp(hi)) return;
      prev = smp(hi);
    end
  endtask

  task automatic measure(input bit hi, output int th, output int tp);
    int tl;
    wait_rise(hi);
    th = 0; tl = 0;
    while (smp(hi) && th < 5000) begin th++; @(negedge clk); end
    while (!smp(hi) && tl < 5000) begin tl++; @(negedge clk); end
    tp = th + tl;
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (pwm_o) h++; end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(5 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int th, tp, h, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pwm_o == 1'b0, "R6 reset output low", pwm_o, 0);

    // R1: halted out of reset, enabled config does nothing until released
    wr(3'd1, 16'd9); wr(3'd2, 16'd3); wr(3'd4, 16'd25);
    count_high(40, h);
    chk(h == 0, "R1 halted after reset", h, 0);
    wr(3'd0, 16'd0);
    n = 0;
    while (!pwm_o && n < 40) begin n++; @(negedge clk); end
    chk(pwm_o == 1'b1, "R1 runs after release", pwm_o, 1);

    // Table: R3 R4 R5 R6
    foreach (VEC[i]) begin
      int m, c, ps, lv, eh, ep;
      m = int'(VEC[i][47:32]); c = int'(VEC[i][31:16]);
      ps = int'(VEC[i][15:8]); lv = int'(VEC[i][7:0]);
      eh = c << ps; ep = (m + 1) << ps;
      setup(m, c, ps, 16 + (lv << 2) + 1);
      measure(lv == 2, th, tp);
      measure(lv == 2, th, tp);
      chk(th == eh, $sformatf("R5 R6 pulse time vec %0d", i), th, eh);
      chk(tp == ep, $sformatf("R3 R4 period vec %0d", i), tp, ep);
    end

    // R2: clear restarts count mid-pulse; R1: halt freezes output
    setup(49, 10, 0, 25);
    wait_rise(1'b1);
    repeat (3) @(negedge clk);
    wr(3'd0, 16'd1);
    count_high(20, h);
    chk(h == 20, "R1 output frozen while halted", h, 20);
    wr(3'd0, 16'd3);
    wr(3'd0, 16'd0);
    n = 0;
    while (pwm_o && n < 100) begin n++; @(negedge clk); end
    chk(n == 10, "R2 clear restarts counter", n, 10);

    // R12: compare beyond modulo -> toggle each wrap
    setup(9, 20, 0, 25);
    measure(1'b1, th, tp); measure(1'b1, th, tp);
    chk(th == 10 && tp == 20, "R12 toggle-only high", th, 10);
    chk(tp == 20, "R12 toggle-only period", tp, 20);

    // R10: toggle-on-wrap clear gives 0%
    setup(9, 3, 0, 9);
    repeat (30) @(negedge clk);
    count_high(40, h);
    chk(h == 0, "R10 zero duty", h, 0);

    // R11: full duty
    setup(9, 3, 0, 32 + 25);
    repeat (30) @(negedge clk);
    count_high(40, h);
    chk(h == 40, "R11 full duty", h, 40);

    // R7: unbuffered write acts inside current period
    setup(99, 10, 0, 25);
    measure(1'b1, th, tp);
    wait_rise(1'b1);
    wr(3'd2, 16'd60);
    n = 2;
    while (pwm_o && n < 300) begin n++; @(negedge clk); end
    chk(n == 60, "R7 unbuffered immediate", n, 60);

    // R8: mode 3 (buffered wins), write idle B is deferred to next wrap
    setup(99, 10, 0, 27);
    measure(1'b1, th, tp);
    wait_rise(1'b1);
    wr(3'd3, 16'd60);
    n = 2;
    while (pwm_o && n < 300) begin n++; @(negedge clk); end
    chk(n == 10, "R8 current period keeps old width", n, 10);
    measure(1'b1, th, tp);
    chk(th == 60, "R8 new width after wrap", th, 60);
    chk(tp == 100, "R8 period unchanged", tp, 100);
    measure(1'b1, th, tp);
    chk(th == 60, "R8 no swap without write", th, 60);

    // R9: write to owning register B acts immediately
    wait_rise(1'b1);
    wr(3'd3, 16'd30);
    n = 2;
    while (pwm_o && n < 300) begin n++; @(negedge clk); end
    chk(n == 30, "R9 active register immediate", n, 30);

    // R6: level select 0 disables output
    wr(3'd4, 16'd17);
    count_high(30, h);
    chk(h == 0, "R6 disabled output low", h, 0);

    summary();
  end
endmodule